// File: doc/BRIEF.md
# Blanking-Gated Asynchronous Character Write Port

This block is the write side of a character display memory. It has 128 positions, and each position holds a 5-bit character code. An outside agent drives a 7-bit position and a 5-bit code onto a parallel port and raises a write strobe. The strobe has no timing relation to the system clock. The block brings the strobe into the clock domain and accepts it only while the display is not in a blanking interval. On acceptance it captures the 12 port bits into a holding register in a single clock. From then on the port is free to change.

The captured word is not written on the strobe. It waits until the display sequencer signals the middle of the next blanking interval with a one-clock strike. On that clock the word goes to the memory write port. The refresh scan, which reads the memory outside blanking, never sees a write in progress.

A strobe that lasts longer than one blanking interval is always accepted. If it begins before blanking, it is qualified before the interval starts. If it begins inside blanking, it is qualified after the interval ends. Each strobe is accepted exactly once.

Top module: `blank_gated_write_port`

## Requirements
- R1: While reset is held, and on the first clock after it is released, the memory write enable is 0, the memory address and data outputs are 0, and no word is pending.
- R2: The 7-bit port address (bit 0 = A0) and 5-bit port code (bit 4 = blank-space flag) are carried unchanged, bit for bit, to the memory address and data outputs when the word is committed.
- R3: A write strobe that rises and falls entirely inside a blanking interval is ignored, and no memory write results from it.
- R4: A write strobe held high for longer than one blanking interval is accepted whatever its alignment to blanking. This covers a strobe that overlaps the start of blanking and a strobe that begins inside blanking.
- R5: Each strobe is captured once. A strobe that is still high across a whole blanking interval gives exactly one memory write.
- R6: Once a strobe has been captured, later changes on the port address and code lines do not alter the committed word.
- R7: The memory write enable rises only on the clock after a commit strike that arrives while blanking is high and a word is pending. It stays high for exactly one clock, so a commit always falls inside a blanking interval.
- R8: A commit strike with no word pending, or a strike that arrives while blanking is low, gives no memory write.
- R9: If a second strobe is captured before the pending word is committed, the second word replaces the first, and only the second word is written.
- R10: A commit clears the pending state, so a later strike gives no further write until a new strobe is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe_i | input | 1 | Asynchronous write strobe from the programming port |
| port_addr_i | input | 7 | Character position on the programming port |
| port_code_i | input | 5 | Character code on the programming port |
| blank_i | input | 1 | High during a display blanking interval |
| commit_strike_i | input | 1 | One-clock pulse at the middle of a blanking interval |
| mem_we_o | output | 1 | Display memory write enable, one clock per commit |
| mem_addr_o | output | 7 | Display memory write address |
| mem_data_o | output | 5 | Display memory write data |

## Verification
The bench builds the block with the default widths, 7 address bits and 5 code bits, and with a two-stage synchronizer. At these widths the extreme positions 0 and 127 and the all-ones code fit in the vector table, together with the code that has only the blank-space flag set. The bench scans frames with a blanking interval of 10 clocks inside a 40-clock period and uses strobes of 14 clocks. These short frames are enough to cover every alignment of the strobe to blanking: strobes wholly visible, overlapping the start of blanking, starting inside blanking, and spanning all of blanking. The bench also checks that each commit lands on the strike clock in the blanking interval that follows the capture.

// File: rtl/bgw_pkg.sv
`timescale 1ns/1ps
package bgw_pkg;
  // Qualification rule: a synchronized strobe counts only outside blanking
  // and only if it has not already been taken during this strobe.
  function automatic logic capture_fire(input logic synced, input logic blank,
                                        input logic taken);
    return synced & ~blank & ~taken;
  endfunction

  // Commit rule: the mid-blanking strike writes a pending word.
  function automatic logic commit_fire(input logic strike, input logic blank,
                                       input logic pending);
    return strike & blank & pending;
  endfunction
endpackage

// File: rtl/bgw_sync.sv
`timescale 1ns/1ps
module bgw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bgw_qualifier.sv
`timescale 1ns/1ps
module bgw_qualifier
  import bgw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic blank_i,
  output logic capture_o
);
  logic taken_q;

  assign capture_o = capture_fire(level_i, blank_i, taken_q);

  // taken stays set until the synchronized strobe falls, so one strobe
  // yields one capture even if blanking splits its visible portion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          taken_q <= 1'b0;
    else if (!level_i)   taken_q <= 1'b0;
    else if (capture_o)  taken_q <= 1'b1;
  end
endmodule

// File: rtl/bgw_holder.sv
`timescale 1ns/1ps
module bgw_holder
  import bgw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              strike_i,
  input  logic              blank_i,
  output logic              pending_o,
  output logic              commit_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_code_q;
  logic              pending_q;

  assign commit_o  = commit_fire(strike_i, blank_i, pending_q);
  assign pending_o = pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_code_q <= '0;
      pending_q   <= 1'b0;
    end else begin
      if (commit_o)  pending_q <= 1'b0;
      if (capture_i) begin
        hold_addr_q <= addr_i;
        hold_code_q <= code_i;
        pending_q   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= commit_o;
      if (commit_o) begin
        mem_addr_o <= hold_addr_q;
        mem_data_o <= hold_code_q;
      end
    end
  end
endmodule

// File: rtl/blank_gated_write_port.sv
`timescale 1ns/1ps
module blank_gated_write_port #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe_i,
  input  logic [ADDR_W-1:0] port_addr_i,
  input  logic [DATA_W-1:0] port_code_i,
  input  logic              blank_i,
  input  logic              commit_strike_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic strobe_sync_w;
  logic capture_w;
  logic pending_w;
  logic commit_w;

  bgw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (wr_strobe_i),
    .q_o   (strobe_sync_w)
  );

  bgw_qualifier u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (strobe_sync_w),
    .blank_i   (blank_i),
    .capture_o (capture_w)
  );

  bgw_holder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture_w),
    .addr_i     (port_addr_i),
    .code_i     (port_code_i),
    .strike_i   (commit_strike_i),
    .blank_i    (blank_i),
    .pending_o  (pending_w),
    .commit_o   (commit_w),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o)
  );
endmodule

// File: rtl/bgw_checker.sv
`timescale 1ns/1ps
module bgw_checker (
  input logic clk,
  input logic rst_n,
  input logic blank_i,
  input logic strike_i,
  input logic capture_w,
  input logic pending_w,
  input logic mem_we_o
);
  // R7
  we_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  // R7
  we_after_strike_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(strike_i && blank_i && pending_w));

  // R3
  capture_outside_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |-> !blank_i);

  // R5
  capture_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> !capture_w);

  // R9
  capture_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> pending_w);

  // R10
  commit_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !pending_w);
endmodule

bind blank_gated_write_port bgw_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blank_i   (blank_i),
  .strike_i  (commit_strike_i),
  .capture_w (capture_w),
  .pending_w (pending_w),
  .mem_we_o  (mem_we_o)
);

// File: tb/blank_gated_write_port_test.sv
`timescale 1ns/1ps
module blank_gated_write_port_test;
  localparam int PERIOD = 40;   // frame length in clocks
  localparam int VIS    = 30;   // blanking occupies cycles VIS..PERIOD-1
  localparam int STRIKE = 35;   // mid-blanking strike
  localparam int SLEN   = 14;   // strobe length, longer than blanking

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [6:0] paddr = '0;
  logic [4:0] pcode = '0;
  logic       blank = 1'b0;
  logic       strike = 1'b0;
  logic       we;
  logic [6:0] maddr;
  logic [4:0] mdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  blank_gated_write_port uut (
    .clk(clk), .rst_n(rst_n), .wr_strobe_i(wr), .port_addr_i(paddr),
    .port_code_i(pcode), .blank_i(blank), .commit_strike_i(strike),
    .mem_we_o(we), .mem_addr_o(maddr), .mem_data_o(mdata)
  );

  // {addr, code, strobe start cycle}
  localparam logic [18:0] VEC [6] = '{
    {7'd0,   5'h00, 7'd2},
    {7'd127, 5'h1F, 7'd24},
    {7'h55,  5'h0E, 7'd32},
    {7'h2A,  5'h07, 7'd24},
    {7'h7F,  5'h10, 7'd32},
    {7'h01,  5'h15, 7'd10}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs two frames with one strobe; records commits.
  task automatic scan(input int start, input int len, input logic [6:0] a,
                      input logic [4:0] c, output int n, output logic [6:0] ca,
                      output logic [4:0] cd, output int ccyc);
    n = 0; ca = '0; cd = '0; ccyc = -1;
    for (int cyc = 0; cyc < 2*PERIOD; cyc++) begin
      @(negedge clk);
      blank  = (cyc % PERIOD) >= VIS;
      strike = (cyc % PERIOD) == STRIKE;
      wr     = (cyc >= start) && (cyc < start + len);
      if (cyc == start) begin paddr = a; pcode = c; end
      if (cyc == start + len + 4) begin paddr = ~a; pcode = ~c; end
      @(posedge clk); #1;
      if (we) begin n++; ca = maddr; cd = mdata; ccyc = cyc; end
    end
    @(negedge clk); blank = 1'b0; strike = 1'b0; wr = 1'b0;
  endtask

  task automatic tick(input logic w, input logic b, input logic s);
    @(negedge clk); wr = w; blank = b; strike = s;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, ccyc, expcyc;
    logic [6:0] ca;
    logic [4:0] cd;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1 check(we == 0 && maddr == 0 && mdata == 0, "R1 reset", {we, maddr, mdata}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(we == 0 && maddr == 0 && mdata == 0, "R1 after release", {we, maddr, mdata}, 0);

    // R8 strike with nothing pending
    tick(0, 1, 1);
    check(we == 0, "R8 idle strike", we, 0);
    tick(0, 1, 0);

    // table walk: R2 R4 R6 R7 R10
    foreach (VEC[i]) begin
      scan(int'(VEC[i][6:0]), SLEN, VEC[i][18:12], VEC[i][11:7], n, ca, cd, ccyc);
      expcyc = (int'(VEC[i][6:0]) < VIS) ? STRIKE : STRIKE + PERIOD;
      check(n == 1, "R4 R10 single commit", n, 1);
      check(ca == VEC[i][18:12] && cd == VEC[i][11:7], "R2 R6 committed word",
            {ca, cd}, {VEC[i][18:12], VEC[i][11:7]});
      check(ccyc == expcyc, "R7 commit on next strike", ccyc, expcyc);
    end

    // R3 strobe wholly inside blanking
    scan(31, 5, 7'h33, 5'h0A, n, ca, cd, ccyc);
    check(n == 0, "R3 strobe in blanking ignored", n, 0);

    // R5 strobe spanning the whole blanking interval
    scan(25, 21, 7'h44, 5'h0B, n, ca, cd, ccyc);
    check(n == 1, "R5 one capture per strobe", n, 1);
    check(ca == 7'h44 && cd == 5'h0B, "R5 word", {ca, cd}, {7'h44, 5'h0B});

    // R9 last write wins; R8 strike outside blanking; R10 no repeat
    paddr = 7'h11; pcode = 5'h03;
    repeat (5) tick(1, 0, 0);
    repeat (5) tick(0, 0, 0);
    paddr = 7'h66; pcode = 5'h1C;
    repeat (5) tick(1, 0, 0);
    repeat (5) tick(0, 0, 0);
    tick(0, 0, 1);
    check(we == 0, "R8 strike without blanking", we, 0);
    tick(0, 1, 0);
    tick(0, 1, 1);
    check(we == 1 && maddr == 7'h66 && mdata == 5'h1C, "R9 last write wins",
          {we, maddr, mdata}, {1'b1, 7'h66, 5'h1C});
    tick(0, 1, 0);
    check(we == 0, "R7 one-clock enable", we, 0);
    tick(0, 1, 1);
    check(we == 0, "R10 pending cleared", we, 0);
    tick(0, 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule